// File: doc/BRIEF.md
# Stack Control-Transfer Sequencer

This block performs the stack-based control transfers of an 8-bit processor core: software break, subroutine call, return from subroutine, return from interrupt, and push or pull of a general register or of the status byte. The core pulses `start` with an operation code and hands over its current program counter, stack pointer, status byte and register value. For a call it also supplies the target address. The sequencer then drives a byte-wide memory port for one access per cycle and returns the updated program counter, stack pointer, status and register.

The stack lives in page 0x01. Every stack address is the page byte concatenated with the 8-bit stack pointer. A push stores at the current pointer and then decrements it. A pull increments the pointer first and then reads. The pointer wraps within 8 bits. Memory reads are combinational: `mem_rdata` must be valid in the same cycle as `mem_addr` and `mem_re`.

Top module: `stk_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are all 0.
- R2: Every stack access uses address {0x01, SP}. A write uses the current SP and leaves SP-1 afterwards. A pull reads at SP+1 and leaves SP+1 afterwards. Both wrap within 8 bits, so SP 0x00 pushes at 0x0100 and SP 0xFF pulls from 0x0100.
- R3: Break (op code 0) works on PC+1. It pushes that value's high byte, then its low byte, then the status byte. It then reads the new PC low byte from 0xFFFE and the high byte from 0xFFFF. The result has SP-3, status bit 2 set, and 5 accesses.
- R4: Call (op code 1) works on PC-1. It pushes that value's high byte, then its low byte. The result is PC equal to the target address and SP-2, after 2 accesses.
- R5: Return from subroutine (op code 2) pulls the PC low byte, then the high byte. The result is PC equal to the pulled value plus 1 (16-bit) and SP+2, after 2 accesses.
- R6: Return from interrupt (op code 3) pulls status, then the PC low byte, then the high byte. The PC is not incremented. The result has SP+3, after 3 accesses.
- R7: Whenever status is pulled (op codes 3 and 7), bits 5 and 4 of the result are forced to 1.
- R8: Pull register (op code 6) returns the pulled byte on `reg_out`. It sets status bit 7 to the byte's bit 7 and status bit 1 to whether the byte is zero. All other status bits are unchanged. SP+1, after 1 access.
- R9: Push register (op code 4) and push status (op code 5) each write one byte at the stack address and change no status bit. SP-1.
- R10: `busy` is high from the cycle after `start` through the last access. Each busy cycle makes exactly one access. `done` is a one-cycle pulse in the first cycle after the last access. A `start` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| op | input | 3 | Operation code (0..7, see requirements) |
| pc_in | input | 16 | Program counter at start |
| sp_in | input | 8 | Stack pointer at start |
| status_in | input | 8 | Status byte at start |
| reg_in | input | 8 | Register value to push |
| tgt_addr | input | 16 | Call target address |
| mem_rdata | input | 8 | Memory read data (same cycle) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 8 | Resulting stack pointer |
| status_out | output | 8 | Resulting status byte |
| reg_out | output | 8 | Pulled register value |

## Verification
A wrong step counter or decode shows up within one cycle as a wrong address, a wrong byte on `mem_wdata`, or a missing strobe. It also shows up at completion as a wrong access count or a misplaced `done`. An off-by-one or a missed wrap in the stack pointer moves the very next stack address away from the page-0x01 slot that was expected. Errors in the byte order or in the PC offsets stay hidden until the operation ends, when `pc_out` or the stack contents disagree with the expected ordering. A status update that is forgotten appears only in `status_out` after `done`.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    OP_BRK  = 3'd0,
    OP_CALL = 3'd1,
    OP_RSUB = 3'd2,
    OP_RINT = 3'd3,
    OP_PSHR = 3'd4,
    OP_PSHS = 3'd5,
    OP_PULR = 3'd6,
    OP_PULS = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {WS_PCH, WS_PCL, WS_ST, WS_RG} wsel_e;
  typedef enum logic [2:0] {RS_NONE, RS_PCL, RS_PCH, RS_ST, RS_RG} rsel_e;

  typedef struct packed {
    logic  wr;
    logic  rd;
    logic  vec;
    wsel_e wsel;
    rsel_e rsel;
    logic  last;
  } acc_t;

  localparam int BIT_N   = 7;
  localparam int BIT_RSV = 5;
  localparam int BIT_BRK = 4;
  localparam int BIT_IRQ = 2;
  localparam int BIT_Z   = 1;

  function automatic logic [DW-1:0] pulled_status(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    r[BIT_RSV] = 1'b1;
    r[BIT_BRK] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/stk_step_decode.sv
module stk_step_decode
  import stk_pkg::*;
(
  input  stk_op_e           op,
  input  logic [STEP_W-1:0] step,
  output acc_t              acc
);
  function automatic acc_t wr_acc(input wsel_e s, input logic l);
    acc_t a;
    a = '{wr: 1'b1, rd: 1'b0, vec: 1'b0, wsel: s, rsel: RS_NONE, last: l};
    return a;
  endfunction

  function automatic acc_t rd_acc(input rsel_e s, input logic v, input logic l);
    acc_t a;
    a = '{wr: 1'b0, rd: 1'b1, vec: v, wsel: WS_PCH, rsel: s, last: l};
    return a;
  endfunction

  always_comb begin
    acc = '{wr: 1'b0, rd: 1'b0, vec: 1'b0, wsel: WS_PCH, rsel: RS_NONE, last: 1'b1};
    unique case (op)
      OP_BRK: begin
        case (step)
          3'd0:    acc = wr_acc(WS_PCH, 1'b0);
          3'd1:    acc = wr_acc(WS_PCL, 1'b0);
          3'd2:    acc = wr_acc(WS_ST,  1'b0);
          3'd3:    acc = rd_acc(RS_PCL, 1'b1, 1'b0);
          3'd4:    acc = rd_acc(RS_PCH, 1'b1, 1'b1);
          default: ;
        endcase
      end
      OP_CALL: begin
        case (step)
          3'd0:    acc = wr_acc(WS_PCH, 1'b0);
          3'd1:    acc = wr_acc(WS_PCL, 1'b1);
          default: ;
        endcase
      end
      OP_RSUB: begin
        case (step)
          3'd0:    acc = rd_acc(RS_PCL, 1'b0, 1'b0);
          3'd1:    acc = rd_acc(RS_PCH, 1'b0, 1'b1);
          default: ;
        endcase
      end
      OP_RINT: begin
        case (step)
          3'd0:    acc = rd_acc(RS_ST,  1'b0, 1'b0);
          3'd1:    acc = rd_acc(RS_PCL, 1'b0, 1'b0);
          3'd2:    acc = rd_acc(RS_PCH, 1'b0, 1'b1);
          default: ;
        endcase
      end
      OP_PSHR: if (step == '0) acc = wr_acc(WS_RG, 1'b1);
      OP_PSHS: if (step == '0) acc = wr_acc(WS_ST, 1'b1);
      OP_PULR: if (step == '0) acc = rd_acc(RS_RG, 1'b0, 1'b1);
      OP_PULS: if (step == '0) acc = rd_acc(RS_ST, 1'b0, 1'b1);
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_port_mux.sv
module stk_port_mux
  import stk_pkg::*;
#(
  parameter logic [DW-1:0] PAGE = 8'h01,
  parameter logic [AW-1:0] VEC  = 16'hFFFE
) (
  input  logic          active,
  input  acc_t          acc,
  input  logic [DW-1:0] sp,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] st,
  input  logic [DW-1:0] rg,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re
);
  logic [DW-1:0] sp_up;
  assign sp_up = sp + 8'd1;

  always_comb begin
    mem_we    = active & acc.wr;
    mem_re    = active & acc.rd;
    mem_addr  = '0;
    mem_wdata = '0;
    if (active) begin
      if (acc.wr)                mem_addr = {PAGE, sp};
      else if (acc.vec)          mem_addr = VEC + {{(AW-1){1'b0}}, (acc.rsel == RS_PCH)};
      else if (acc.rd)           mem_addr = {PAGE, sp_up};
      if (acc.wr) begin
        case (acc.wsel)
          WS_PCH:  mem_wdata = pc[AW-1:DW];
          WS_PCL:  mem_wdata = pc[DW-1:0];
          WS_ST:   mem_wdata = st;
          default: mem_wdata = rg;
        endcase
      end
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter logic [7:0]  PAGE = 8'h01,
  parameter logic [15:0] VEC  = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [15:0] pc_in,
  input  logic [7:0]  sp_in,
  input  logic [7:0]  status_in,
  input  logic [7:0]  reg_in,
  input  logic [15:0] tgt_addr,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [7:0]  sp_out,
  output logic [7:0]  status_out,
  output logic [7:0]  reg_out
);
  logic              rst_n_s;
  logic              busy_q, busy_n, done_q, done_n;
  logic [STEP_W-1:0] step_q, step_n;
  stk_op_e           op_q, op_n;
  logic [AW-1:0]     pc_q, pc_n, tgt_q, tgt_n, pc_start;
  logic [DW-1:0]     sp_q, sp_n, st_q, st_n, rg_q, rg_n;
  logic              ld_en;
  acc_t              acc;

  stk_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  stk_step_decode u_dec (.op(op_q), .step(step_q), .acc(acc));

  stk_port_mux #(.PAGE(PAGE), .VEC(VEC)) u_mux (
    .active(busy_q), .acc(acc), .sp(sp_q), .pc(pc_q), .st(st_q), .rg(rg_q),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  always_comb begin
    case (stk_op_e'(op))
      OP_BRK:  pc_start = pc_in + 16'd1;
      OP_CALL: pc_start = pc_in - 16'd1;
      default: pc_start = pc_in;
    endcase
  end

  assign ld_en = busy_q | start;

  always_comb begin
    busy_n = busy_q;
    step_n = step_q;
    op_n   = op_q;
    pc_n   = pc_q;
    sp_n   = sp_q;
    st_n   = st_q;
    rg_n   = rg_q;
    tgt_n  = tgt_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        step_n = '0;
        op_n   = stk_op_e'(op);
        pc_n   = pc_start;
        sp_n   = sp_in;
        st_n   = status_in;
        rg_n   = reg_in;
        tgt_n  = tgt_addr;
      end
    end else begin
      step_n = step_q + 1'b1;
      if (acc.wr)                  sp_n = sp_q - 8'd1;
      else if (acc.rd && !acc.vec) sp_n = sp_q + 8'd1;
      case (acc.rsel)
        RS_PCL: pc_n[DW-1:0]  = mem_rdata;
        RS_PCH: pc_n[AW-1:DW] = mem_rdata;
        RS_ST:  st_n = pulled_status(mem_rdata);
        RS_RG: begin
          rg_n        = mem_rdata;
          st_n[BIT_N] = mem_rdata[7];
          st_n[BIT_Z] = (mem_rdata == '0);
        end
        default: ;
      endcase
      if (acc.wr && acc.wsel == WS_ST && op_q == OP_BRK) st_n[BIT_IRQ] = 1'b1;
      if (acc.last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        if (op_q == OP_CALL) pc_n = tgt_q;
        if (op_q == OP_RSUB) pc_n = {mem_rdata, pc_q[DW-1:0]} + 16'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      op_q   <= OP_BRK;
      pc_q   <= '0;
      tgt_q  <= '0;
      sp_q   <= '0;
      st_q   <= '0;
      rg_q   <= '0;
    end else begin
      done_q <= done_n;
      if (ld_en) begin
        busy_q <= busy_n;
        step_q <= step_n;
        op_q   <= op_n;
        pc_q   <= pc_n;
        tgt_q  <= tgt_n;
        sp_q   <= sp_n;
        st_q   <= st_n;
        rg_q   <= rg_n;
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign pc_out     = pc_q;
  assign sp_out     = sp_q;
  assign status_out = st_q;
  assign reg_out    = rg_q;
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter logic [7:0]  PAGE = 8'h01,
  parameter logic [15:0] VEC  = 16'hFFFE
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp_out,
  input logic [7:0]  status_out,
  input logic [2:0]  op_q
);
  assert_addr_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr[15:8] == PAGE || mem_addr[15:1] == VEC[15:1]));

  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(sp_out) - 8'd1));

  assert_pull_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_addr[15:8] == PAGE) |=> (sp_out == $past(sp_out) + 8'd1));

  assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_we ^ mem_re));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || mem_re));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_brk_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 3'd0) |-> status_out[2]);

  assert_status_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == 3'd3 || op_q == 3'd7)) |-> (status_out[5:4] == 2'b11));
endmodule

bind stk_seq stk_seq_chk #(.PAGE(PAGE), .VEC(VEC)) u_stk_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
  .mem_re(mem_re), .mem_addr(mem_addr), .sp_out(sp_out),
  .status_out(status_out), .op_q(op_q)
);

// File: tb/tb_stk_seq.sv
module tb_stk_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] pc_in = '0, tgt_addr = '0;
  logic [7:0]  sp_in = '0, status_in = '0, reg_in = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, sp_out, status_out, reg_out;
  logic        mem_we, mem_re, busy, done;

  logic [7:0] smem [0:255];
  logic [7:0] vec_lo = 8'h34, vec_hi = 8'h12;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
    .sp_in(sp_in), .status_in(status_in), .reg_in(reg_in), .tgt_addr(tgt_addr),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done),
    .pc_out(pc_out), .sp_out(sp_out), .status_out(status_out), .reg_out(reg_out)
  );

  always_comb begin
    if (mem_addr[15:8] == 8'h01)  mem_rdata = smem[mem_addr[7:0]];
    else if (mem_addr == 16'hFFFE) mem_rdata = vec_lo;
    else if (mem_addr == 16'hFFFF) mem_rdata = vec_hi;
    else                           mem_rdata = 8'hEE;
  end

  always @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h01) smem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd6: return "R8";
      3'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [15:0] pc, input logic [7:0] sp,
                        input logic [7:0] st, input logic [7:0] rg, input logic [15:0] tgt,
                        input bit disturb);
    logic [15:0] e_pc, tmp;
    logic [7:0]  e_sp, e_st, e_rg, p1, p2, p3;
    logic [7:0]  wa [3];
    logic [7:0]  wd [3];
    int nw, e_n, n;
    string rq;
    rq = req_of(o);
    p1 = smem[8'(sp + 8'd1)];
    p2 = smem[8'(sp + 8'd2)];
    p3 = smem[8'(sp + 8'd3)];
    e_pc = pc; e_sp = sp; e_st = st; e_rg = rg; nw = 0; e_n = 1;
    for (int i = 0; i < 3; i++) begin wa[i] = '0; wd[i] = '0; end
    case (o)
      3'd0: begin
        tmp = pc + 16'd1;
        wa[0] = sp; wd[0] = tmp[15:8];
        wa[1] = sp - 8'd1; wd[1] = tmp[7:0];
        wa[2] = sp - 8'd2; wd[2] = st;
        nw = 3; e_pc = {vec_hi, vec_lo}; e_sp = sp - 8'd3; e_st = st | 8'h04; e_n = 5;
      end
      3'd1: begin
        tmp = pc - 16'd1;
        wa[0] = sp; wd[0] = tmp[15:8];
        wa[1] = sp - 8'd1; wd[1] = tmp[7:0];
        nw = 2; e_pc = tgt; e_sp = sp - 8'd2; e_n = 2;
      end
      3'd2: begin e_pc = {p2, p1} + 16'd1; e_sp = sp + 8'd2; e_n = 2; end
      3'd3: begin e_st = p1 | 8'h30; e_pc = {p3, p2}; e_sp = sp + 8'd3; e_n = 3; end
      3'd4: begin wa[0] = sp; wd[0] = rg; nw = 1; e_sp = sp - 8'd1; end
      3'd5: begin wa[0] = sp; wd[0] = st; nw = 1; e_sp = sp - 8'd1; end
      3'd6: begin e_rg = p1; e_st[7] = p1[7]; e_st[1] = (p1 == 8'h00); e_sp = sp + 8'd1; end
      default: begin e_st = p1 | 8'h30; e_sp = sp + 8'd1; end
    endcase

    @(negedge clk);
    op = o; pc_in = pc; sp_in = sp; status_in = st; reg_in = rg; tgt_addr = tgt; start = 1'b1;
    @(negedge clk);
    if (disturb) begin op = ~o; pc_in = ~pc; sp_in = ~sp; reg_in = ~rg; end
    else start = 1'b0;
    chk("R10", "busy after start", busy, 1'b1);
    n = 0;
    while (busy && n < 20) begin
      n++;
      @(negedge clk);
      start = 1'b0;
    end
    chk("R10", "done pulse", done, 1'b1);
    chk(rq, "access count", n, e_n);
    chk(rq, "pc_out", pc_out, e_pc);
    chk("R2", "sp_out", sp_out, e_sp);
    chk(rq, "status_out", status_out, e_st);
    chk(rq, "reg_out", reg_out, e_rg);
    for (int i = 0; i < nw; i++) chk(rq, "stack byte", smem[wa[i]], wd[i]);
    @(negedge clk);
    chk("R10", "done drops", done, 1'b0);
    chk("R10", "idle after done", busy, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) smem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "done", done, 1'b0);
    chk("R1", "mem_we", mem_we, 1'b0);
    chk("R1", "mem_re", mem_re, 1'b0);

    // R3 break with PC wrap
    run_op(3'd0, 16'hFFFF, 8'hF0, 8'h81, 8'h00, 16'h0, 0);
    // R4 call with borrow across low byte
    run_op(3'd1, 16'h2300, 8'h80, 8'h00, 8'h00, 16'hBEEF, 0);
    // R5 return with carry into high byte
    smem[8'h41] = 8'hFF; smem[8'h42] = 8'h12;
    run_op(3'd2, 16'h0, 8'h40, 8'h00, 8'h00, 16'h0, 0);
    // R6 / R7 return from interrupt, pulled status 0x00
    smem[8'h51] = 8'h00; smem[8'h52] = 8'h78; smem[8'h53] = 8'h56;
    run_op(3'd3, 16'h0, 8'h50, 8'hFF, 8'h00, 16'h0, 0);
    // R2 push wraps from SP 0x00 to 0xFF
    run_op(3'd4, 16'h0, 8'h00, 8'h00, 8'hA5, 16'h0, 0);
    // R2 pull wraps from SP 0xFF; R8 zero flag
    smem[8'h00] = 8'h00;
    run_op(3'd6, 16'h0, 8'hFF, 8'h80, 8'h11, 16'h0, 0);
    // R8 negative flag
    smem[8'h61] = 8'h80;
    run_op(3'd6, 16'h0, 8'h60, 8'h02, 8'h11, 16'h0, 0);
    // R7 pull status forces bits
    smem[8'h71] = 8'h00;
    run_op(3'd7, 16'h0, 8'h70, 8'hFF, 8'h00, 16'h0, 0);
    // R9 push status; R10 start held while busy is ignored
    run_op(3'd5, 16'h0, 8'h90, 8'h5A, 8'h00, 16'h0, 1);
    run_op(3'd0, 16'h1234, 8'h02, 8'h00, 8'h00, 16'h0, 1);

    for (int k = 0; k < 60; k++) begin
      logic [7:0] s;
      s = 8'($urandom);
      for (int j = 1; j <= 3; j++) smem[8'(s + 8'(j))] = 8'($urandom);
      run_op(3'($urandom), 16'($urandom), s, 8'($urandom), 8'($urandom), 16'($urandom), 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule